// File: doc/BRIEF.md
# ADC Reconfiguration Safety Sequencer

This block sits between a register write path and the control bits of an analog-to-digital converter. It makes two dangerous operations safe: changing the sample-overlap mode bit and pulsing the converter's soft reset. If either lands while a conversion is running, the converter locks up until the whole device is reset. A caller asks for one of the two operations. The sequencer then drains the converter and applies the write only once nothing can still be converting.

The drain runs in a fixed order. First it saves, then zeroes, the sixteen hardware trigger-select fields of the start-of-conversion slots; zero means software triggering only. Next it saves, then zeroes, the sixteen interrupt-retrigger bits, which are written as two groups of eight. It then polls the sixteen pending-start flags until all of them read zero. After that it counts the worst-case conversion time for the present clock divider. Only then does it issue the requested write. Finally it restores the saved trigger and retrigger settings and signals completion. A request that arrives while a sequence is running is refused through the ready signal and is not stored.

States and transitions: IDLE goes to CLR_TRIG when a request is accepted. CLR_TRIG goes to CLR_RETRIG, and CLR_RETRIG goes to POLL. POLL stays in POLL while any pending flag is set and goes to WAIT once all flags are clear, loading the drain timer. WAIT goes to COMMIT when the timer reaches zero. COMMIT goes to RESTORE, RESTORE goes to FINISH, and FINISH goes back to IDLE.

Top module: `adc_cfg_guard`

## Requirements
- R1: After reset, req_ready is 1 and tsel_wr, retrig_wr, ovl_wr, conv_soft_rst and seq_done are all 0.
- R2: One cycle after a request is accepted (req_valid and req_ready at a clock edge), tsel_wr is 1 with tsel_wdata all zero and retrig_wr is 0. The trigger-select values present at acceptance are captured.
- R3: In the following cycle, retrig_wr is 1 for both groups (bit g covers slots 8g to 8g+7), retrig_wdata is all zero and tsel_wr is 0. The retrigger values present at acceptance are captured.
- R4: While any bit of pend_flags is 1 in the polling state, the block issues no commit and stays in that state.
- R5: Let N = (acq_win + 13) × F, where F is 1 when clk_div2 is 0 (whatever clk_div4 is), 2 when clk_div2 is 1 and clk_div4 is 0, and 4 when both are 1. Take the first clock edge in the polling state at which pend_flags reads zero. The commit appears N + 1 cycles after that edge.
- R6: A commit lasts one cycle. For req_kind 0 it raises ovl_wr with ovl_wdata equal to req_ovl as it was at acceptance. For req_kind 1 it raises conv_soft_rst. The two are never 1 together.
- R7: The cycle after the commit, tsel_wr is 1 and retrig_wr is 1 for both groups, and each carries the values captured at acceptance.
- R8: seq_done is 1 for exactly one cycle, two cycles after the commit. req_ready is 1 again in the next cycle.
- R9: req_ready is 0 from acceptance until after seq_done. A request raised while req_ready is 0 is dropped and never produces a commit.
- R10: The drain counter covers the largest case, acq_win = 63 with F = 4, which is 304 cycles, without wrapping.
- R11: A conversion started by the last pending flag to clear has always finished before the overlap or reset write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_kind | input | 1 | 0 = overlap-mode write, 1 = converter soft reset |
| req_ovl | input | 1 | New overlap-mode value for kind 0 |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| acq_win | input | ACQ_W (6) | Acquisition window setting used in the drain length |
| clk_div2 | input | 1 | Converter clock divide-by-2 enable |
| clk_div4 | input | 1 | Converter clock divide-by-4 enable |
| tsel_cur | input | NUM_SLOTS*TSEL_W (80) | Present trigger-select fields, slot 0 in the low bits |
| retrig_cur | input | NUM_SLOTS (16) | Present interrupt-retrigger bits, one per slot |
| pend_flags | input | NUM_SLOTS (16) | Pending start-of-conversion flags |
| tsel_wr | output | 1 | Write strobe for all trigger-select fields |
| tsel_wdata | output | NUM_SLOTS*TSEL_W (80) | Trigger-select write data |
| retrig_wr | output | NUM_SLOTS/8 (2) | Per-group write strobe for retrigger bits |
| retrig_wdata | output | NUM_SLOTS (16) | Retrigger write data |
| ovl_wr | output | 1 | Write strobe for the overlap-mode bit |
| ovl_wdata | output | 1 | Overlap-mode write value |
| conv_soft_rst | output | 1 | One-cycle soft reset pulse to the converter |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
Sequences are run across all four divider settings, with the acquisition window at 0, mid-range values and the maximum of 63. This separates the three multiplication factors and shows that the combination with divide-by-2 off and divide-by-4 on still gives a factor of one. The pending flags are released at different distances from acceptance, both before the polling state is reached and well after it. These cases separate an exact count from the first clear poll from one taken from acceptance. Each sequence starts from a different saved register pattern, so the restore step can be told apart from one that writes zeros or reads live values. A converter model marks a hang if a commit lands inside a conversion.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR_TRIG,
        ST_CLR_RETRIG,
        ST_POLL,
        ST_WAIT,
        ST_COMMIT,
        ST_RESTORE,
        ST_FINISH
    } guard_state_e;

    typedef enum logic {
        OP_OVERLAP = 1'b0,
        OP_RESET   = 1'b1
    } guard_op_e;

endpackage

// File: rtl/guard_fsm.sv
module guard_fsm
    import adc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic pend_any,
    input  logic timer_zero,
    output logic req_ready,
    output logic capture,
    output logic clr_trig,
    output logic clr_retrig,
    output logic timer_load,
    output logic timer_run,
    output logic commit,
    output logic restore,
    output logic done
);

    guard_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_CLR_TRIG;
            ST_CLR_TRIG:   state_d = ST_CLR_RETRIG;
            ST_CLR_RETRIG: state_d = ST_POLL;
            ST_POLL:       if (!pend_any) state_d = ST_WAIT;
            ST_WAIT:       if (timer_zero) state_d = ST_COMMIT;
            ST_COMMIT:     state_d = ST_RESTORE;
            ST_RESTORE:    state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Moore outputs, plus the accept and load qualifiers
    always_comb begin
        req_ready  = 1'b0;
        capture    = 1'b0;
        clr_trig   = 1'b0;
        clr_retrig = 1'b0;
        timer_load = 1'b0;
        timer_run  = 1'b0;
        commit     = 1'b0;
        restore    = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                capture   = req_valid;
            end
            ST_CLR_TRIG:   clr_trig   = 1'b1;
            ST_CLR_RETRIG: clr_retrig = 1'b1;
            ST_POLL:       timer_load = !pend_any;
            ST_WAIT:       timer_run  = 1'b1;
            ST_COMMIT:     commit     = 1'b1;
            ST_RESTORE:    restore    = 1'b1;
            ST_FINISH:     done       = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/drain_timer.sv
module drain_timer #(
    parameter int ACQ_W      = 6,
    parameter int ACQ_OFFSET = 13,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [ACQ_W-1:0] acq_win,
    input  logic             clk_div2,
    input  logic             clk_div4,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] full_len;
    logic [1:0]       shift_amt;

    always_comb begin
        base_len = CNT_W'(acq_win) + CNT_W'(ACQ_OFFSET);
        if (!clk_div2) begin
            shift_amt = 2'd0;
        end else if (!clk_div4) begin
            shift_amt = 2'd1;
        end else begin
            shift_amt = 2'd2;
        end
        full_len = base_len << shift_amt;
    end

    // loaded with length-1 so the wait state lasts exactly full_len cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= full_len - 1'b1;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/shadow_store.sv
module shadow_store #(
    parameter int NUM_SLOTS = 16,
    parameter int TSEL_W    = 5,
    parameter int GRP_SLOTS = 8,
    localparam int NUM_GRP  = NUM_SLOTS / GRP_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic                        clr_trig,
    input  logic                        clr_retrig,
    input  logic                        restore,
    input  logic [NUM_SLOTS*TSEL_W-1:0] tsel_cur,
    input  logic [NUM_SLOTS-1:0]        retrig_cur,
    output logic                        tsel_wr,
    output logic [NUM_SLOTS*TSEL_W-1:0] tsel_wdata,
    output logic [NUM_GRP-1:0]          retrig_wr,
    output logic [NUM_SLOTS-1:0]        retrig_wdata
);

    logic [NUM_SLOTS*TSEL_W-1:0] tsel_sh;
    logic [NUM_SLOTS-1:0]        retrig_sh;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tsel_sh[s*TSEL_W +: TSEL_W] <= '0;
                retrig_sh[s]                <= 1'b0;
            end else if (capture) begin
                tsel_sh[s*TSEL_W +: TSEL_W] <= tsel_cur[s*TSEL_W +: TSEL_W];
                retrig_sh[s]                <= retrig_cur[s];
            end
        end
        assign tsel_wdata[s*TSEL_W +: TSEL_W] = restore ? tsel_sh[s*TSEL_W +: TSEL_W] : '0;
        assign retrig_wdata[s]                = restore ? retrig_sh[s] : 1'b0;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign retrig_wr[g] = clr_retrig | restore;
    end

    assign tsel_wr = clr_trig | restore;

endmodule

// File: rtl/adc_cfg_guard.sv
module adc_cfg_guard
    import adc_guard_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int TSEL_W     = 5,
    parameter int GRP_SLOTS  = 8,
    parameter int ACQ_W      = 6,
    parameter int ACQ_OFFSET = 13,
    localparam int NUM_GRP   = NUM_SLOTS / GRP_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_kind,
    input  logic                        req_ovl,
    output logic                        req_ready,
    input  logic [ACQ_W-1:0]            acq_win,
    input  logic                        clk_div2,
    input  logic                        clk_div4,
    input  logic [NUM_SLOTS*TSEL_W-1:0] tsel_cur,
    input  logic [NUM_SLOTS-1:0]        retrig_cur,
    input  logic [NUM_SLOTS-1:0]        pend_flags,
    output logic                        tsel_wr,
    output logic [NUM_SLOTS*TSEL_W-1:0] tsel_wdata,
    output logic [NUM_GRP-1:0]          retrig_wr,
    output logic [NUM_SLOTS-1:0]        retrig_wdata,
    output logic                        ovl_wr,
    output logic                        ovl_wdata,
    output logic                        conv_soft_rst,
    output logic                        seq_done
);

    localparam int MAX_LEN = ((1 << ACQ_W) - 1 + ACQ_OFFSET) * 4;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic      pend_any;
    logic      capture, clr_trig, clr_retrig, timer_load, timer_run;
    logic      commit, restore, timer_zero;
    guard_op_e op_q;
    logic      ovl_q;

    assign pend_any = |pend_flags;

    guard_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .pend_any   (pend_any),
        .timer_zero (timer_zero),
        .req_ready  (req_ready),
        .capture    (capture),
        .clr_trig   (clr_trig),
        .clr_retrig (clr_retrig),
        .timer_load (timer_load),
        .timer_run  (timer_run),
        .commit     (commit),
        .restore    (restore),
        .done       (seq_done)
    );

    drain_timer #(
        .ACQ_W      (ACQ_W),
        .ACQ_OFFSET (ACQ_OFFSET),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .run      (timer_run),
        .acq_win  (acq_win),
        .clk_div2 (clk_div2),
        .clk_div4 (clk_div4),
        .expired  (timer_zero)
    );

    shadow_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .TSEL_W    (TSEL_W),
        .GRP_SLOTS (GRP_SLOTS)
    ) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .clr_trig     (clr_trig),
        .clr_retrig   (clr_retrig),
        .restore      (restore),
        .tsel_cur     (tsel_cur),
        .retrig_cur   (retrig_cur),
        .tsel_wr      (tsel_wr),
        .tsel_wdata   (tsel_wdata),
        .retrig_wr    (retrig_wr),
        .retrig_wdata (retrig_wdata)
    );

    // requested operation held for the whole sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_OVERLAP;
            ovl_q <= 1'b0;
        end else if (capture) begin
            op_q  <= guard_op_e'(req_kind);
            ovl_q <= req_ovl;
        end
    end

    assign ovl_wr        = commit && (op_q == OP_OVERLAP);
    assign conv_soft_rst = commit && (op_q == OP_RESET);
    assign ovl_wdata     = ovl_q;

endmodule

// File: rtl/adc_cfg_guard_chk.sv
module adc_cfg_guard_chk #(
    parameter int NUM_SLOTS  = 16,
    parameter int TSEL_W     = 5,
    parameter int GRP_SLOTS  = 8,
    parameter int ACQ_W      = 6,
    parameter int ACQ_OFFSET = 13,
    localparam int NUM_GRP   = NUM_SLOTS / GRP_SLOTS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [ACQ_W-1:0]            acq_win,
    input logic                        clk_div2,
    input logic                        clk_div4,
    input logic [NUM_SLOTS-1:0]        pend_flags,
    input logic                        tsel_wr,
    input logic [NUM_SLOTS*TSEL_W-1:0] tsel_wdata,
    input logic [NUM_GRP-1:0]          retrig_wr,
    input logic [NUM_SLOTS-1:0]        retrig_wdata,
    input logic                        ovl_wr,
    input logic                        conv_soft_rst,
    input logic                        seq_done
);

    localparam int LIM = ((1 << ACQ_W) - 1 + ACQ_OFFSET) * 4 + 1;
    localparam int QW  = $clog2(LIM + 1);

    logic [QW-1:0] quiet;
    int            need;
    int            fac;

    // cycles since pending flags were last seen non-zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (pend_flags != '0) begin
            quiet <= '0;
        end else if (quiet != QW'(LIM)) begin
            quiet <= quiet + 1'b1;
        end
    end

    always_comb begin
        fac  = clk_div2 ? (clk_div4 ? 4 : 2) : 1;
        need = (int'(acq_win) + ACQ_OFFSET) * fac;
    end

    p_clear_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (tsel_wr && (tsel_wdata == '0) && (retrig_wr == '0)));

    p_clear_retrig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel_wr && (retrig_wr == '0)) |=> ((retrig_wr == '1) && (retrig_wdata == '0) && !tsel_wr));

    p_drain_elapsed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_wr || conv_soft_rst) |-> (int'(quiet) > need));

    p_single_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovl_wr && conv_soft_rst));

    p_restore_after_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_wr || conv_soft_rst) |=> (tsel_wr && (retrig_wr == '1)));

    p_done_after_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ($past(tsel_wr) && !req_ready));

    p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (req_ready && !seq_done));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel_wr || ovl_wr || conv_soft_rst || seq_done) |-> !req_ready);

endmodule

bind adc_cfg_guard adc_cfg_guard_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .TSEL_W     (TSEL_W),
    .GRP_SLOTS  (GRP_SLOTS),
    .ACQ_W      (ACQ_W),
    .ACQ_OFFSET (ACQ_OFFSET)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .acq_win       (acq_win),
    .clk_div2      (clk_div2),
    .clk_div4      (clk_div4),
    .pend_flags    (pend_flags),
    .tsel_wr       (tsel_wr),
    .tsel_wdata    (tsel_wdata),
    .retrig_wr     (retrig_wr),
    .retrig_wdata  (retrig_wdata),
    .ovl_wr        (ovl_wr),
    .conv_soft_rst (conv_soft_rst),
    .seq_done      (seq_done)
);

// File: tb/adc_cfg_guard_tb.sv
`timescale 1ns/1ps
module adc_cfg_guard_tb;

    localparam int NS = 16;
    localparam int TW = 5;
    localparam int GS = 8;
    localparam int AW = 6;
    localparam int NG = NS / GS;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic            rst_n;
    logic            req_valid, req_kind, req_ovl, req_ready;
    logic [AW-1:0]   acq_win;
    logic            clk_div2, clk_div4;
    logic [NS*TW-1:0] tsel_reg;
    logic [NS-1:0]   retrig_reg;
    logic [NS-1:0]   pend;
    logic            tsel_wr;
    logic [NS*TW-1:0] tsel_wdata;
    logic [NG-1:0]   retrig_wr;
    logic [NS-1:0]   retrig_wdata;
    logic            ovl_wr, ovl_wdata, conv_soft_rst, seq_done;

    adc_cfg_guard u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_ovl       (req_ovl),
        .req_ready     (req_ready),
        .acq_win       (acq_win),
        .clk_div2      (clk_div2),
        .clk_div4      (clk_div4),
        .tsel_cur      (tsel_reg),
        .retrig_cur    (retrig_reg),
        .pend_flags    (pend),
        .tsel_wr       (tsel_wr),
        .tsel_wdata    (tsel_wdata),
        .retrig_wr     (retrig_wr),
        .retrig_wdata  (retrig_wdata),
        .ovl_wr        (ovl_wr),
        .ovl_wdata     (ovl_wdata),
        .conv_soft_rst (conv_soft_rst),
        .seq_done      (seq_done)
    );

    typedef struct {
        bit               kind;
        bit               val;
        int               exp_cyc;
        logic [NS*TW-1:0] orig_t;
        logic [NS-1:0]    orig_r;
    } item_t;

    item_t sb_q[$];
    item_t cur;

    int  cyc = 0;
    int  errors = 0;
    int  checks = 0;
    int  accept_cyc = -100;
    int  commit_cyc = -100;
    int  busy_left = 0;
    int  model_len = 13;
    bit  hung = 1'b0;
    bit  finished = 1'b0;
    logic [NS-1:0] prev_pend = '0;

    logic             preset_en;
    logic [NS*TW-1:0] preset_t;
    logic [NS-1:0]    preset_r;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // register file the block writes into
    always @(posedge clk) begin
        if (preset_en) begin
            tsel_reg   <= preset_t;
            retrig_reg <= preset_r;
        end else begin
            if (tsel_wr) tsel_reg <= tsel_wdata;
            for (int g = 0; g < NG; g++) begin
                if (retrig_wr[g]) retrig_reg[g*GS +: GS] <= retrig_wdata[g*GS +: GS];
            end
        end
    end

    // cycle counter and converter model (R11)
    always @(posedge clk) begin
        cyc = cyc + 1;
        if ((ovl_wr || conv_soft_rst) && busy_left > 0) hung = 1'b1;
        if (prev_pend != '0 && pend == '0) busy_left = model_len;
        else if (busy_left > 0) busy_left = busy_left - 1;
        prev_pend = pend;
    end

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovl_wr && conv_soft_rst) chk("R6", "both commit strobes", 1, 0);
            if (ovl_wr || conv_soft_rst) begin
                if (sb_q.size() == 0) begin
                    chk("R9", "unexpected commit", 1, 0);
                end else begin
                    cur = sb_q.pop_front();
                    chk("R6", "commit kind", 128'(conv_soft_rst), 128'(cur.kind));
                    if (!cur.kind) chk("R6", "overlap value", 128'(ovl_wdata), 128'(cur.val));
                    chk("R5", "commit cycle", 128'(cyc), 128'(cur.exp_cyc));
                    chk("R2", "trigger selects zero at commit", 128'(tsel_reg), 0);
                    chk("R3", "retrigger bits zero at commit", 128'(retrig_reg), 0);
                    commit_cyc = cyc;
                end
            end
            if (tsel_wr && retrig_wr == '0) begin
                chk("R2", "trigger clear cycle", 128'(cyc), 128'(accept_cyc + 1));
                chk("R2", "trigger clear data", 128'(tsel_wdata), 0);
            end
            if (retrig_wr == '1 && !tsel_wr) begin
                chk("R3", "retrigger clear cycle", 128'(cyc), 128'(accept_cyc + 2));
                chk("R3", "retrigger clear data", 128'(retrig_wdata), 0);
            end
            if (seq_done) begin
                chk("R8", "done cycle", 128'(cyc), 128'(commit_cyc + 2));
                chk("R7", "trigger selects restored", 128'(tsel_reg), 128'(cur.orig_t));
                chk("R7", "retrigger bits restored", 128'(retrig_reg), 128'(cur.orig_r));
            end
        end
    end

    // driver: one guarded operation, expected result pushed to the queue
    task automatic run_seq(input bit kind, input bit val, input int acq,
                           input bit d2, input bit d4, input int hold,
                           input logic [NS*TW-1:0] tp, input logic [NS-1:0] rp);
        int n0, len, exp_c;
        item_t it;
        @(negedge clk);
        preset_en = 1'b1; preset_t = tp; preset_r = rp;
        @(negedge clk);
        preset_en = 1'b0;
        acq_win  = AW'(acq);
        clk_div2 = d2;
        clk_div4 = d4;
        pend     = 16'h8001;
        len = (acq + 13) * (d2 ? (d4 ? 4 : 2) : 1);
        model_len = len;
        chk("R9", "ready before request", 128'(req_ready), 1);
        req_valid = 1'b1; req_kind = kind; req_ovl = val;
        n0 = cyc;
        accept_cyc = n0;
        exp_c = n0 + ((hold > 3) ? hold : 3) + len + 1;
        it.kind = kind; it.val = val; it.exp_cyc = exp_c; it.orig_t = tp; it.orig_r = rp;
        sb_q.push_back(it);
        for (int k = 1; k < 2000; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                chk("R9", "ready low after accept", 128'(req_ready), 0);
            end
            if (k == hold) begin
                chk("R4", "no commit while flags pending", 128'({ovl_wr, conv_soft_rst}), 0);
                pend = '0;
            end
            if (k == 5) begin
                req_valid = 1'b1; req_kind = ~kind;
                chk("R9", "ready low mid-sequence", 128'(req_ready), 0);
            end
            if (k == 6) req_valid = 1'b0;
            if (n0 + k == exp_c + 3) begin
                chk("R8", "ready after done", 128'(req_ready), 1);
                break;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_kind = 1'b0; req_ovl = 1'b0;
        acq_win = '0; clk_div2 = 1'b0; clk_div4 = 1'b0;
        pend = '0;
        preset_en = 1'b1; preset_t = '0; preset_r = '0;
        repeat (3) @(negedge clk);
        preset_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 128'(req_ready), 1);
        chk("R1", "strobes idle after reset",
            128'({tsel_wr, retrig_wr, ovl_wr, conv_soft_rst, seq_done}), 0);

        run_seq(1'b0, 1'b1, 6,  1'b1, 1'b0, 1,  80'h1234_5678_9abc_def0_1357, 16'hA5C3);
        run_seq(1'b1, 1'b0, 0,  1'b0, 1'b1, 10, 80'hffff_0000_ffff_0000_ffff, 16'h00FF);
        run_seq(1'b0, 1'b0, 20, 1'b0, 1'b0, 3,  80'h0f0f_0f0f_0f0f_0f0f_0f0f, 16'hFF00);
        // R10: longest drain, 304 cycles
        run_seq(1'b1, 1'b0, 63, 1'b1, 1'b1, 5,  80'h8421_8421_8421_8421_8421, 16'h1248);
        run_seq(1'b0, 1'b1, 5,  1'b1, 1'b1, 40, 80'hdead_beef_cafe_f00d_0042, 16'h7E81);

        repeat (4) @(negedge clk);
        chk("R11", "converter hang flag", 128'(hung), 0);
        chk("R9", "scoreboard empty", 128'(sb_q.size()), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule